// File: doc/BRIEF.md
# Five-State Snooping Coherence Controller

This block keeps the coherence state of every line of one private write-back cache attached to a shared snooping bus. Each line is in one of five states: Invalid, Shared, Exclusive, Owned or Modified. Owned marks a line that other caches may also hold, while this cache alone carries the newest data and the duty to write it back. The controller is direct-mapped and stores only a tag and a state per line. Data payloads are left out, so a dirty state stands in for data that memory does not yet have.

The processor side is a valid/ready request stream. A request is taken when `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` stays low until the request ends with a one-cycle `cpu_done` pulse. On the bus side the controller raises `bus_req_valid` with a command and an address. The transaction completes in the cycle where `bus_req_ready` is high, and `bus_shared` is sampled in that same cycle. While `bus_req_ready` is low, the request is held unchanged. The one exception is a snoop: a snoop has priority and may withdraw or change a pending request, since it can alter the line.

Snoops from other caches arrive as `snoop_valid`, `snoop_cmd` and `snoop_addr`. The controller answers in the same cycle on `snoop_shared` and `snoop_supply`, and updates the line at the next clock edge.

Top module: `moesi_ctrl`

## Requirements
- R1: After reset every line is Invalid and `cpu_req_ready` is high with no bus request, so the first access to any address misses.
- R2: A processor read that hits a valid line with a matching tag completes with no bus request and leaves the line's state unchanged.
- R3: A read miss issues a bus read (command 0). The line fills as Exclusive when `bus_shared` is low at the grant, and as Shared when it is high.
- R4: A processor write that hits a line in Exclusive or Modified completes with no bus request and leaves the line Modified.
- R5: A write that hits a line in Shared or Owned issues an upgrade (command 2). A write that misses issues a read-exclusive (command 1). Either way the line ends Modified.
- R6: A snooped read (command 0) that hits a valid line raises `snoop_shared`. `snoop_supply` is raised only when the line is Modified or Owned. Modified becomes Owned and Exclusive becomes Shared, with no write-back. Shared and Owned keep their state.
- R7: A snooped read-exclusive or upgrade that hits a line invalidates it. `snoop_supply` is raised in that cycle when the line was Modified or Owned.
- R8: A miss whose victim line is Modified or Owned first issues a write-back (command 3) carrying the victim's address, then the fill. A clean victim is replaced silently.
- R9: While a request is in progress, `cpu_req_ready` is low. A bus request that has not been granted keeps its command and address until granted, unless a snoop arrives.
- R10: While `snoop_valid` is high, the controller neither raises `bus_req_valid` nor completes a processor request.
- R11: A snoop that misses, or that carries a write-back command, raises neither response signal and leaves the cache unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can take a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address (tag above index) |
| cpu_done | output | 1 | One-cycle pulse when the request finishes |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_ready | input | 1 | Bus grants and completes the transaction this cycle |
| bus_req_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 write-back |
| bus_req_addr | output | ADDR_W | Address of the transaction |
| bus_shared | input | 1 | Another cache holds the line, sampled at grant |
| snoop_valid | input | 1 | Snooped transaction from another cache |
| snoop_cmd | input | 2 | Snooped command, same encoding as `bus_req_cmd` |
| snoop_addr | input | ADDR_W | Snooped address |
| snoop_shared | output | 1 | This cache holds the snooped line |
| snoop_supply | output | 1 | This cache drives the line's data |

## Verification
The assertions take for granted that snoops never coincide with this controller's own granted bus transaction, because a single bus carries one transaction per cycle. They also assume `cpu_req_valid` is only offered while `cpu_req_ready` is high. The stimulus meets both conditions. It drives snoops only between processor operations, or at one deliberate point in a busy period before any grant. It raises each processor request for exactly one accepted cycle. Under these conditions the stability check on the bus request and the invalidation and ownership checks across back-to-back snoops are meaningful.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_RDX = 2'd1,
    CMD_UPG = 2'd2,
    CMD_WB  = 2'd3
  } bus_cmd_e;

  function automatic logic st_dirty(line_st_e s);
    return (s == ST_O) || (s == ST_M);
  endfunction
endpackage

// File: rtl/moesi_array.sv
module moesi_array
  import moesi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_e         wr_st,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [TAG_W-1:0] ra_tag,
  output line_st_e         ra_st,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [TAG_W-1:0] rb_tag,
  output line_st_e         rb_st
);
  localparam int NLINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [NLINES];
  line_st_e         st_q  [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[g] <= '0;
        st_q[g]  <= ST_I;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        tag_q[g] <= wr_tag;
        st_q[g]  <= wr_st;
      end
    end
  end

  assign ra_tag = tag_q[ra_idx];
  assign ra_st  = st_q[ra_idx];
  assign rb_tag = tag_q[rb_idx];
  assign rb_st  = st_q[rb_idx];
endmodule

// File: rtl/moesi_snoop.sv
module moesi_snoop
  import moesi_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             snoop_valid,
  input  bus_cmd_e         snoop_cmd,
  input  logic [TAG_W-1:0] snoop_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_e         line_st,
  output logic             shared_o,
  output logic             supply_o,
  output logic             upd_en,
  output line_st_e         upd_st
);
  logic hit;
  assign hit = snoop_valid && (line_st != ST_I) && (line_tag == snoop_tag);

  always_comb begin
    shared_o = 1'b0;
    supply_o = 1'b0;
    upd_en   = 1'b0;
    upd_st   = line_st;
    if (hit) begin
      unique case (snoop_cmd)
        CMD_RD: begin
          shared_o = 1'b1;
          supply_o = st_dirty(line_st);
          if (line_st == ST_M) begin
            upd_en = 1'b1;
            upd_st = ST_O;
          end else if (line_st == ST_E) begin
            upd_en = 1'b1;
            upd_st = ST_S;
          end
        end
        CMD_RDX, CMD_UPG: begin
          supply_o = st_dirty(line_st);
          upd_en   = 1'b1;
          upd_st   = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/moesi_req.sv
module moesi_req
  import moesi_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             busy,
  input  logic             stall,
  input  logic             req_write,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_e         line_st,
  input  logic             bus_ready,
  input  logic             bus_shared,
  output logic             bus_valid,
  output bus_cmd_e         bus_cmd,
  output logic             use_victim,
  output logic             done,
  output logic             upd_en,
  output logic [TAG_W-1:0] upd_tag,
  output line_st_e         upd_st
);
  logic hit, need_bus, grant;

  assign hit = (line_st != ST_I) && (line_tag == req_tag);

  always_comb begin
    need_bus   = 1'b1;
    use_victim = 1'b0;
    bus_cmd    = CMD_RD;
    if (!hit && st_dirty(line_st)) begin
      bus_cmd    = CMD_WB;
      use_victim = 1'b1;
    end else if (!hit) begin
      bus_cmd = req_write ? CMD_RDX : CMD_RD;
    end else if (req_write && (line_st == ST_S || line_st == ST_O)) begin
      bus_cmd = CMD_UPG;
    end else begin
      need_bus = 1'b0;
    end
  end

  assign bus_valid = busy && need_bus && !stall;
  assign done      = busy && !need_bus && !stall;
  assign grant     = bus_valid && bus_ready;

  always_comb begin
    upd_en  = 1'b0;
    upd_tag = req_tag;
    upd_st  = line_st;
    if (grant) begin
      upd_en = 1'b1;
      unique case (bus_cmd)
        CMD_WB: begin
          upd_tag = line_tag;
          upd_st  = ST_I;
        end
        CMD_RD:  upd_st = bus_shared ? ST_S : ST_E;
        default: upd_st = ST_M;
      endcase
    end else if (done && req_write && line_st == ST_E) begin
      upd_en = 1'b1;
      upd_st = ST_M;
    end
  end
endmodule

// File: rtl/moesi_ctrl.sv
module moesi_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_done,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_shared,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_shared,
  output logic              snoop_supply
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              busy_q, wr_q;
  logic [ADDR_W-1:0] addr_q;

  logic [IDX_W-1:0] req_idx, snp_idx;
  logic [TAG_W-1:0] req_tag, snp_tag, a_tag, b_tag, r_tag;
  line_st_e         a_st, b_st, s_st, r_st, w_st;
  logic             s_upd, r_upd, use_victim;
  bus_cmd_e         cmd;

  assign req_idx = addr_q[IDX_W-1:0];
  assign req_tag = addr_q[ADDR_W-1:IDX_W];
  assign snp_idx = snoop_addr[IDX_W-1:0];
  assign snp_tag = snoop_addr[ADDR_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else if (!busy_q && cpu_req_valid) begin
      busy_q <= 1'b1;
      wr_q   <= cpu_req_write;
      addr_q <= cpu_req_addr;
    end else if (cpu_done) begin
      busy_q <= 1'b0;
    end
  end

  moesi_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (s_upd || r_upd),
    .wr_idx (s_upd ? snp_idx : req_idx),
    .wr_tag (s_upd ? b_tag : r_tag),
    .wr_st  (w_st),
    .ra_idx (req_idx),
    .ra_tag (a_tag),
    .ra_st  (a_st),
    .rb_idx (snp_idx),
    .rb_tag (b_tag),
    .rb_st  (b_st)
  );

  assign w_st = s_upd ? s_st : r_st;

  moesi_snoop #(.TAG_W(TAG_W)) u_snoop (
    .snoop_valid (snoop_valid),
    .snoop_cmd   (bus_cmd_e'(snoop_cmd)),
    .snoop_tag   (snp_tag),
    .line_tag    (b_tag),
    .line_st     (b_st),
    .shared_o    (snoop_shared),
    .supply_o    (snoop_supply),
    .upd_en      (s_upd),
    .upd_st      (s_st)
  );

  moesi_req #(.TAG_W(TAG_W)) u_req (
    .busy       (busy_q),
    .stall      (snoop_valid),
    .req_write  (wr_q),
    .req_tag    (req_tag),
    .line_tag   (a_tag),
    .line_st    (a_st),
    .bus_ready  (bus_req_ready),
    .bus_shared (bus_shared),
    .bus_valid  (bus_req_valid),
    .bus_cmd    (cmd),
    .use_victim (use_victim),
    .done       (cpu_done),
    .upd_en     (r_upd),
    .upd_tag    (r_tag),
    .upd_st     (r_st)
  );

  assign cpu_req_ready = !busy_q;
  assign bus_req_cmd   = cmd;
  assign bus_req_addr  = use_victim ? {a_tag, req_idx} : addr_q;
endmodule

// File: rtl/moesi_ctrl_chk.sv
module moesi_ctrl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_ready,
  input logic              cpu_done,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic [1:0]        bus_req_cmd,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              snoop_valid,
  input logic [1:0]        snoop_cmd,
  input logic [ADDR_W-1:0] snoop_addr,
  input logic              snoop_shared,
  input logic              snoop_supply
);
  assert_shared_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_shared |-> (snoop_valid && snoop_cmd == 2'd0));

  assert_supply_on_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_supply |-> (snoop_valid && snoop_cmd != 2'd3));

  assert_snoop_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid |-> (!bus_req_valid && !cpu_done));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid || cpu_done) |-> !cpu_req_ready);

  assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready && !snoop_valid) |=>
      (snoop_valid || (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr))));

  assert_invalidated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && (snoop_cmd == 2'd1 || snoop_cmd == 2'd2)) |=>
      ((snoop_valid && snoop_cmd == 2'd0 && snoop_addr == $past(snoop_addr)) -> !snoop_shared));

  assert_owner_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_cmd == 2'd0 && snoop_supply) |=>
      ((snoop_valid && snoop_cmd == 2'd0 && snoop_addr == $past(snoop_addr)) -> snoop_supply));
endmodule

bind moesi_ctrl moesi_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_ready (cpu_req_ready),
  .cpu_done      (cpu_done),
  .bus_req_valid (bus_req_valid),
  .bus_req_ready (bus_req_ready),
  .bus_req_cmd   (bus_req_cmd),
  .bus_req_addr  (bus_req_addr),
  .snoop_valid   (snoop_valid),
  .snoop_cmd     (snoop_cmd),
  .snoop_addr    (snoop_addr),
  .snoop_shared  (snoop_shared),
  .snoop_supply  (snoop_supply)
);

// File: tb/moesi_ctrl_tb.sv
module moesi_ctrl_tb;
  localparam int AW = 6;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic cpu_req_ready, cpu_done;
  logic bus_req_valid, bus_req_ready = 1'b1, bus_shared = 1'b0;
  logic [1:0] bus_req_cmd;
  logic [AW-1:0] bus_req_addr;
  logic snoop_valid = 1'b0;
  logic [1:0] snoop_cmd = 2'd0;
  logic [AW-1:0] snoop_addr = '0;
  logic snoop_shared, snoop_supply;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  int mst [4];
  int mtag [4];

  always #2 clk = ~clk;

  moesi_ctrl #(.ADDR_W(AW), .IDX_W(IW)) u_dut (.*);

  task automatic check(bit ok, string rq, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // expected behaviour: state codes I=0 S=1 E=2 O=3 M=4, commands RD=0 RDX=1 UPG=2 WB=3
  task automatic do_cpu(bit wr, logic [AW-1:0] a, bit shr, int hold, bit mid_snoop);
    int idx = int'(a[IW-1:0]);
    int tg = int'(a[AW-1:IW]);
    int st = mst[idx];
    bit hit = (st != 0) && (mtag[idx] == tg);
    int en = 0, gn = 0;
    int ec [3];
    int ea [3];
    int gc [3];
    int ga [3];
    bit done = 0;
    string rq;
    if (!hit && st >= 3) begin
      ec[en] = 3; ea[en] = (mtag[idx] << IW) | idx; en++; rq = "R8";
    end
    if (!hit) begin
      ec[en] = wr ? 1 : 0; ea[en] = int'(a); en++;
      if (rq == "") rq = wr ? "R5" : "R3";
      mst[idx] = wr ? 4 : (shr ? 1 : 2); mtag[idx] = tg;
    end else if (wr && (st == 1 || st == 3)) begin
      ec[en] = 2; ea[en] = int'(a); en++; rq = "R5"; mst[idx] = 4;
    end else if (wr) begin
      rq = "R4"; mst[idx] = 4;
    end else rq = "R2";
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; bus_shared = shr;
    #1 check(cpu_req_ready == 1'b1, "R9", "ready when idle", cpu_req_ready, 1);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (mid_snoop) begin
      snoop_valid = 1'b1; snoop_cmd = 2'd3; snoop_addr = a ^ 6'h01;
      #1 check(!bus_req_valid && !cpu_done, "R10", "busy output during snoop",
               {bus_req_valid, cpu_done}, 0);
      @(negedge clk);
      snoop_valid = 1'b0;
    end
    for (int cyc = 0; cyc < 20 && !done; cyc++) begin
      bus_req_ready = (hold == 0);
      #1;
      if (bus_req_valid && !bus_req_ready) begin
        check(!cpu_req_ready && gn < 3 && en > 0 && int'(bus_req_cmd) == ec[0],
              "R9", "held request", bus_req_cmd, ec[0]);
        hold--;
      end else if (bus_req_valid) begin
        if (gn < 3) begin gc[gn] = int'(bus_req_cmd); ga[gn] = int'(bus_req_addr); end
        gn++;
      end
      if (cpu_done) done = 1;
      @(negedge clk);
    end
    bus_req_ready = 1'b1;
    check(done, rq, "request completed", done, 1);
    check(gn == en, rq, "bus transaction count", gn, en);
    for (int k = 0; k < en && k < gn; k++) begin
      check(gc[k] == ec[k], rq, "bus command", gc[k], ec[k]);
      check(ga[k] == ea[k], rq, "bus address", ga[k], ea[k]);
    end
  endtask

  task automatic do_snoop(int cmd, logic [AW-1:0] a);
    int idx = int'(a[IW-1:0]);
    int tg = int'(a[AW-1:IW]);
    int st = mst[idx];
    bit hit = (st != 0) && (mtag[idx] == tg);
    bit sh = 0, sup = 0;
    string rq = "R11";
    if (hit && cmd == 0) begin
      rq = "R6"; sh = 1; sup = (st >= 3);
      if (st == 4) mst[idx] = 3; else if (st == 2) mst[idx] = 1;
    end else if (hit && (cmd == 1 || cmd == 2)) begin
      rq = "R7"; sup = (st >= 3); mst[idx] = 0;
    end
    @(negedge clk);
    snoop_valid = 1'b1; snoop_cmd = 2'(cmd); snoop_addr = a;
    #1 check({snoop_shared, snoop_supply} == {sh, sup}, rq, "snoop response",
             {snoop_shared, snoop_supply}, {sh, sup});
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic make_state(int s, logic [AW-1:0] a);
    case (s)
      1: do_cpu(0, a, 1, 0, 0);
      2: do_cpu(0, a, 0, 0, 0);
      3: begin do_cpu(1, a, 0, 0, 0); do_snoop(0, a); end
      4: do_cpu(1, a, 0, 0, 0);
      default: ;
    endcase
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin mst[i] = 0; mtag[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check(cpu_req_ready && !bus_req_valid && !cpu_done, "R1", "reset outputs",
             {cpu_req_ready, bus_req_valid, cpu_done}, 3'b100);
    for (int i = 0; i < 4; i++) do_cpu(0, 6'(i), 0, 0, 0);  // R1: all miss first

    for (int idx = 0; idx < 4; idx++)
      for (int s = 0; s < 5; s++)
        for (int op = 0; op < 8; op++) begin
          logic [AW-1:0] a = 6'((((idx + s + op) % 7 + 1) << IW) | idx);
          logic [AW-1:0] b = a ^ 6'h20;
          do_snoop(1, 6'((mtag[idx] << IW) | idx));
          make_state(s, a);
          case (op)
            0: do_cpu(0, a, 0, 0, 0);
            1: do_cpu(1, a, 0, 0, 0);
            2: do_snoop(0, a);
            3: do_snoop(1, a);
            4: do_snoop(2, a);
            5: do_snoop(3, a);
            6: do_cpu(0, b, op[0], 0, 0);
            default: do_snoop(0, b);
          endcase
          do_snoop(0, a);
        end

    // R9 back-pressure on a dirty eviction and on a fill
    do_snoop(1, 6'((mtag[2] << IW) | 2));
    do_cpu(1, 6'h0a, 0, 0, 0);
    do_cpu(0, 6'h2a, 1, 3, 0);
    // R10 snoop during a busy period
    do_cpu(1, 6'h2a, 0, 0, 1);
    do_cpu(0, 6'h17, 0, 2, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule